// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a two-port memory in which the storage is cut into a fixed set of independent banks. Each bank is an ordinary single-port synchronous SRAM. Each port presents a bank number and a word offset inside that bank, together with an enable, a write flag and write data. Both ports run on one shared clock. A port's bank number alone routes that port's access to a bank. No separate bank-select inputs exist.

The two ports are served in the same cycle when they name different banks. When both ports are enabled and name the same bank, neither access is carried out, whatever their word offsets are. Both ports then raise a conflict flag in that same cycle. The block does not pick a winner. An arbiter outside the block watches the flags and retries one of the accesses.

A granted read returns its word, marked valid, one clock after the request is sampled. In every other cycle the read-data output keeps its last value and is marked invalid. The default build has 64 banks and a small word address width, so that elaboration stays light. The word address width is a parameter and can be set to 12 for full-size banks.

Top module: `bank_switched_dpram`

## Requirements
- R1: Both ports reach one shared storage. A word written through either port at bank B, offset W can be read back through the other port at bank B, offset W. The default bank count is 64, addressed by a 6-bit bank number.
- R2: An enabled read (enable 1, write flag 0) with no conflict presents the stored word on the read-data output and sets read-valid to 1 in the clock cycle after the request is sampled.
- R3: When both ports are enabled and their bank numbers differ, both accesses are carried out in the same cycle, and neither conflict flag is raised.
- R4: When both ports are enabled and their bank numbers are equal, both conflict flags are 1 during that same cycle, with no register on the path.
- R5: A write that is blocked by a conflict leaves every stored word unchanged.
- R6: A read that is blocked by a conflict yields read-valid 0 in the following cycle, and the read-data output keeps its previous value.
- R7: The conflict flags stay 0 when at most one port is enabled, even if the two bank numbers are equal. A lone enabled port is always served.
- R8: Conflicts are judged per bank. Two accesses to the same bank at different word offsets still conflict.
- R9: During and straight after reset, both read-valid outputs are 0 and both read-data outputs are 0.
- R10: A granted write gives read-valid 0 in the next cycle on the writing port, and that port's read-data output keeps its previous value.
- R11: Equal word offsets in different banks are separate storage locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| pa_en | input | 1 | Port A access enable |
| pa_we | input | 1 | Port A write flag (1 = write, 0 = read) |
| pa_bank | input | BANK_AW | Port A bank number |
| pa_word | input | WORD_AW | Port A word offset inside the bank |
| pa_wdata | input | DATA_W | Port A write data |
| pa_rdata | output | DATA_W | Port A read data, held while not valid |
| pa_rvalid | output | 1 | Port A read data valid |
| pa_conflict | output | 1 | Port A access blocked this cycle |
| pb_en | input | 1 | Port B access enable |
| pb_we | input | 1 | Port B write flag (1 = write, 0 = read) |
| pb_bank | input | BANK_AW | Port B bank number |
| pb_word | input | WORD_AW | Port B word offset inside the bank |
| pb_wdata | input | DATA_W | Port B write data |
| pb_rdata | output | DATA_W | Port B read data, held while not valid |
| pb_rvalid | output | 1 | Port B read data valid |
| pb_conflict | output | 1 | Port B access blocked this cycle |

## Verification
Two functions can fall in the same cycle: serving two accesses side by side, and blocking both when they meet in one bank. The bench drives both ports in the same cycle, first with differing bank numbers and then with equal bank numbers but different offsets. It judges the conflict flags combinationally before the clock edge. After the edge it judges the outcome at the ports, from read-valid, held read data and a later read-back of the words a blocked write aimed at. An idle partner on the same bank number shows that only enabled accesses can collide.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

   // Kind of access a port performs in a cycle after conflict screening
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   function automatic acc_e classify(input logic en, input logic we, input logic blocked);
      if (!en || blocked) return ACC_NONE;
      return we ? ACC_WRITE : ACC_READ;
   endfunction

endpackage

// File: rtl/bsw_clash.sv
// Bank-level collision detector: both ports active on one bank number.
module bsw_clash #(
   parameter int BANK_AW = 6
) (
   input  logic               a_en,
   input  logic [BANK_AW-1:0] a_bank,
   input  logic               b_en,
   input  logic [BANK_AW-1:0] b_bank,
   output logic               clash
);
   logic same_bank;
   assign same_bank = (a_bank == b_bank);
   assign clash     = a_en & b_en & same_bank;
endmodule

// File: rtl/bsw_steer.sv
// Turns one port's bank number into a one-hot bank select vector.
module bsw_steer #(
   parameter int BANK_AW = 6
) (
   input  bsw_pkg::acc_e             kind,
   input  logic [BANK_AW-1:0]        bank,
   output logic [(1<<BANK_AW)-1:0]   sel
);
   import bsw_pkg::*;
   localparam int NUM_BANKS = 1 << BANK_AW;

   logic active;
   assign active = (kind != ACC_NONE);

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
      assign sel[g] = active & (bank == BANK_AW'(g));
   end
endmodule

// File: rtl/bsw_bank.sv
// One bank: single-port synchronous SRAM fed by whichever port owns it.
module bsw_bank #(
   parameter int WORD_AW = 4,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sel_a,
   input  logic               we_a,
   input  logic [WORD_AW-1:0] addr_a,
   input  logic [DATA_W-1:0]  wd_a,
   input  logic               sel_b,
   input  logic               we_b,
   input  logic [WORD_AW-1:0] addr_b,
   input  logic [DATA_W-1:0]  wd_b,
   output logic [DATA_W-1:0]  q
);
   localparam int WORDS = 1 << WORD_AW;

   logic [DATA_W-1:0]  mem [WORDS];
   logic               act;
   logic               wr;
   logic [WORD_AW-1:0] addr;
   logic [DATA_W-1:0]  wd;

   always_comb begin
      act  = sel_a | sel_b;
      wr   = sel_a ? we_a   : we_b;
      addr = sel_a ? addr_a : addr_b;
      wd   = sel_a ? wd_a   : wd_b;
   end

   always_ff @(posedge clk) begin
      if (act && wr) mem[addr] <= wd;
   end

   always_ff @(posedge clk) begin
      if (rst)              q <= '0;
      else if (act && !wr)  q <= mem[addr];
   end

   // R3
   single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      !(sel_a && sel_b));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(sel_a || sel_b) |=> $stable(q));
endmodule

// File: rtl/bsw_return.sv
// Per-port read return: picks the bank read last cycle, holds otherwise.
module bsw_return #(
   parameter int BANK_AW = 6,
   parameter int DATA_W  = 16
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  bsw_pkg::acc_e                        kind,
   input  logic [BANK_AW-1:0]                   bank,
   input  logic [(1<<BANK_AW)-1:0][DATA_W-1:0]  bank_q,
   output logic [DATA_W-1:0]                    rd_data,
   output logic                                 rd_valid
);
   import bsw_pkg::*;

   logic [BANK_AW-1:0] bank_r;
   logic [DATA_W-1:0]  hold_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         bank_r   <= '0;
      end else begin
         rd_valid <= (kind == ACC_READ);
         if (kind == ACC_READ) bank_r <= bank;
      end
   end

   assign rd_data = rd_valid ? bank_q[bank_r] : hold_r;

   always_ff @(posedge clk) begin
      if (rst) hold_r <= '0;
      else     hold_r <= rd_data;
   end
endmodule

// File: rtl/bank_switched_dpram.sv
module bank_switched_dpram #(
   parameter int BANK_AW = 6,
   parameter int WORD_AW = 4,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pa_en,
   input  logic               pa_we,
   input  logic [BANK_AW-1:0] pa_bank,
   input  logic [WORD_AW-1:0] pa_word,
   input  logic [DATA_W-1:0]  pa_wdata,
   output logic [DATA_W-1:0]  pa_rdata,
   output logic               pa_rvalid,
   output logic               pa_conflict,
   input  logic               pb_en,
   input  logic               pb_we,
   input  logic [BANK_AW-1:0] pb_bank,
   input  logic [WORD_AW-1:0] pb_word,
   input  logic [DATA_W-1:0]  pb_wdata,
   output logic [DATA_W-1:0]  pb_rdata,
   output logic               pb_rvalid,
   output logic               pb_conflict
);
   import bsw_pkg::*;
   localparam int NUM_BANKS = 1 << BANK_AW;

   initial begin : param_chk
      assert (BANK_AW >= 1 && BANK_AW <= 8) else $error("BANK_AW out of range");
      assert (WORD_AW >= 1 && WORD_AW <= 16) else $error("WORD_AW out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic                                clash;
   acc_e                                kind_a, kind_b;
   logic [NUM_BANKS-1:0]                sel_a, sel_b;
   logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_q;

   bsw_clash #(.BANK_AW(BANK_AW)) u_clash (
      .a_en(pa_en), .a_bank(pa_bank),
      .b_en(pb_en), .b_bank(pb_bank),
      .clash(clash)
   );

   assign pa_conflict = clash;
   assign pb_conflict = clash;
   assign kind_a = classify(pa_en, pa_we, clash);
   assign kind_b = classify(pb_en, pb_we, clash);

   bsw_steer #(.BANK_AW(BANK_AW)) u_steer_a (.kind(kind_a), .bank(pa_bank), .sel(sel_a));
   bsw_steer #(.BANK_AW(BANK_AW)) u_steer_b (.kind(kind_b), .bank(pb_bank), .sel(sel_b));

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      bsw_bank #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_bank (
         .clk(clk), .rst(rst),
         .sel_a(sel_a[g]), .we_a(pa_we), .addr_a(pa_word), .wd_a(pa_wdata),
         .sel_b(sel_b[g]), .we_b(pb_we), .addr_b(pb_word), .wd_b(pb_wdata),
         .q(bank_q[g])
      );
   end

   bsw_return #(.BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_ret_a (
      .clk(clk), .rst(rst), .kind(kind_a), .bank(pa_bank), .bank_q(bank_q),
      .rd_data(pa_rdata), .rd_valid(pa_rvalid)
   );
   bsw_return #(.BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_ret_b (
      .clk(clk), .rst(rst), .kind(kind_b), .bank(pb_bank), .bank_q(bank_q),
      .rd_data(pb_rdata), .rd_valid(pb_rvalid)
   );

   // R4
   conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (pa_en && pb_en && pa_bank == pb_bank) |-> (pa_conflict && pb_conflict));

   // R5
   blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
      clash |-> (sel_a == '0 && sel_b == '0));

   // R2
   read_latency_chk: assert property (@(posedge clk) disable iff (rst)
      pa_rvalid |-> $past(pa_en && !pa_we && !pa_conflict));

   // R6
   read_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pb_rvalid |-> $stable(pb_rdata));

   // R7
   idle_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
      !(pa_en && pb_en) |-> !(pa_conflict || pb_conflict));
endmodule

// File: tb/bank_switched_dpram_test.sv
module bank_switched_dpram_test;
   localparam int BANK_AW = 6;
   localparam int WORD_AW = 4;
   localparam int DATA_W  = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pa_en = 0, pa_we = 0, pb_en = 0, pb_we = 0;
   logic [BANK_AW-1:0] pa_bank = '0, pb_bank = '0;
   logic [WORD_AW-1:0] pa_word = '0, pb_word = '0;
   logic [DATA_W-1:0]  pa_wdata = '0, pb_wdata = '0;
   logic [DATA_W-1:0]  pa_rdata, pb_rdata;
   logic pa_rvalid, pb_rvalid, pa_conflict, pb_conflict;

   int n_chk = 0;
   int n_bad = 0;
   logic ca_s, cb_s;

   always #10 clk = ~clk;

   bank_switched_dpram #(.BANK_AW(BANK_AW), .WORD_AW(WORD_AW), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst(rst),
      .pa_en(pa_en), .pa_we(pa_we), .pa_bank(pa_bank), .pa_word(pa_word),
      .pa_wdata(pa_wdata), .pa_rdata(pa_rdata), .pa_rvalid(pa_rvalid), .pa_conflict(pa_conflict),
      .pb_en(pb_en), .pb_we(pb_we), .pb_bank(pb_bank), .pb_word(pb_word),
      .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .pb_rvalid(pb_rvalid), .pb_conflict(pb_conflict)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle on both ports; conflict flags sampled before the edge,
   // returns shortly after the edge so registered outputs can be read.
   task automatic cyc(input logic ea, input logic wa, input int ba, input int aa, input int da,
                      input logic eb, input logic wb, input int bb, input int ab, input int db);
      @(negedge clk);
      pa_en = ea; pa_we = wa; pa_bank = BANK_AW'(ba); pa_word = WORD_AW'(aa); pa_wdata = DATA_W'(da);
      pb_en = eb; pb_we = wb; pb_bank = BANK_AW'(bb); pb_word = WORD_AW'(ab); pb_wdata = DATA_W'(db);
      #3;
      ca_s = pa_conflict; cb_s = pb_conflict;
      @(posedge clk);
      #2;
      pa_en = 0; pb_en = 0;
   endtask

   task automatic t_reset();
      check("R9 a_rvalid", pa_rvalid, 0);
      check("R9 b_rvalid", pb_rvalid, 0);
      check("R9 a_rdata", pa_rdata, 0);
      check("R9 b_rdata", pb_rdata, 0);
      check("R9 conflict", pa_conflict | pb_conflict, 0);
   endtask

   task automatic t_shared();
      cyc(1, 1, 5, 3, 16'hA55A, 0, 0, 0, 0, 0);
      check("R10 write gives no valid", pa_rvalid, 0);
      check("R10 write keeps rdata", pa_rdata, 0);
      cyc(0, 0, 0, 0, 0, 1, 0, 5, 3, 0);
      check("R2 b_rvalid", pb_rvalid, 1);
      check("R1 shared word via B", pb_rdata, 16'hA55A);
   endtask

   task automatic t_parallel();
      cyc(1, 1, 10, 1, 16'h1010, 1, 1, 20, 1, 16'h2020);
      check("R3 no conflict a", ca_s, 0);
      check("R3 no conflict b", cb_s, 0);
      cyc(1, 0, 20, 1, 0, 1, 0, 10, 1, 0);
      check("R3 a valid", pa_rvalid, 1);
      check("R3 a data", pa_rdata, 16'h2020);
      check("R3 b valid", pb_rvalid, 1);
      check("R3 b data", pb_rdata, 16'h1010);
   endtask

   task automatic t_banks_apart();
      cyc(1, 1, 1, 7, 16'h0111, 0, 0, 0, 0, 0);
      cyc(1, 1, 2, 7, 16'h0222, 0, 0, 0, 0, 0);
      cyc(1, 0, 1, 7, 0, 1, 0, 2, 7, 0);
      check("R11 bank1 word7", pa_rdata, 16'h0111);
      check("R11 bank2 word7", pb_rdata, 16'h0222);
   endtask

   task automatic t_conflict_write();
      cyc(1, 1, 30, 2, 16'hBEEF, 1, 1, 31, 5, 16'hCAFE);
      cyc(0, 0, 0, 0, 0, 1, 1, 30, 5, 16'h5555);
      cyc(1, 1, 30, 2, 16'hDEAD, 1, 1, 30, 5, 16'h7777);
      check("R4 a flag", ca_s, 1);
      check("R4 b flag", cb_s, 1);
      check("R8 different words still clash", ca_s & cb_s, 1);
      cyc(1, 0, 30, 2, 0, 1, 0, 31, 5, 0);
      check("R5 word2 unchanged", pa_rdata, 16'hBEEF);
      cyc(1, 0, 30, 5, 0, 0, 0, 0, 0, 0);
      check("R5 word5 unchanged", pa_rdata, 16'h5555);
   endtask

   task automatic t_conflict_read();
      cyc(1, 0, 10, 1, 0, 1, 0, 20, 1, 0);
      check("R2 a pre-read", pa_rdata, 16'h1010);
      cyc(1, 0, 40, 0, 0, 1, 0, 40, 3, 0);
      check("R4 read clash flag", ca_s, 1);
      check("R6 a rvalid low", pa_rvalid, 0);
      check("R6 a rdata held", pa_rdata, 16'h1010);
      check("R6 b rdata held", pb_rdata, 16'h2020);
   endtask

   task automatic t_idle_partner();
      cyc(1, 1, 50, 4, 16'h4444, 0, 0, 50, 4, 0);
      check("R7 idle partner no flag", ca_s | cb_s, 0);
      cyc(0, 0, 50, 4, 0, 1, 0, 50, 4, 0);
      check("R7 lone port served", pb_rdata, 16'h4444);
      check("R7 lone port valid", pb_rvalid, 1);
      cyc(1, 1, 50, 9, 16'h9999, 0, 0, 0, 0, 0);
      check("R10 held after write", pa_rdata, 16'h1010);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      #3;
      t_reset();
      t_shared();
      t_parallel();
      t_banks_apart();
      t_conflict_write();
      t_conflict_read();
      t_idle_partner();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule